// File: doc/BRIEF.md
# Floating-Point Register Load/Store Unit

This unit carries out the word-sized transfers between memory and a floating-point register file. An instruction arrives as decoded fields plus the values already read from the general and floating-point register files. The unit computes an effective address and checks that it is legal and aligned. It then issues one memory request and returns the results as register write strobes. There are two addressing forms. The indexed form adds two general registers. The immediate form adds an 8-bit unsigned offset, scaled by four, to a base register. Either form can copy the effective address back into the base register once the access has finished.

The unit takes one instruction at a time over a valid/ready handshake. It is ready only when it is idle. Encoding faults, a missing floating-point option and misaligned addresses are each reported as a one-cycle exception pulse. An instruction that faults touches neither memory nor any register.

Top module: `fpls_unit`

## Requirements
- R1: In the indexed form (`in_form`=0) the effective address is `in_base_val + in_index_val`, taken modulo 2^32.
- R2: In the immediate form (`in_form`=1) the effective address is `in_base_val + (in_imm << 2)`, with the immediate zero-extended and the sum taken modulo 2^32.
- R3: In the indexed form, the sub-opcode `in_op2` must be 0, 1, 4 or 5. Bit 2 selects store and bit 0 selects base update. Any other value pulses `exc_reserved` for one cycle and has no other effect.
- R4: In the immediate form, the `in_r` field must be 0, 4, 8 or 12. Bit 2 selects store and bit 3 selects base update. Any other value pulses `exc_reserved` for one cycle and has no other effect.
- R5: A load issues a read request. When the response arrives, it pulses `fp_wr_en` once with the 32-bit response word. The FP register index is `in_r` in the indexed form and `in_t` in the immediate form.
- R6: A store issues a write request with `mem_req_we`=1 and `mem_req_wdata`=`in_fp_val`. It produces no FP register write.
- R7: A base update pulses `base_wr_en` with index `in_s` and the effective address as data. The pulse comes only after the memory response, in the same cycle as any load write.
- R8: An effective address with either of its two low bits set pulses `exc_align`. It issues no memory request and writes no register.
- R9: A legal encoding with `in_fp_present`=0 pulses `exc_no_fp` and has no other effect. A reserved encoding reports `exc_reserved` even when the option is absent. At most one exception pulses in any cycle.
- R10: After reset `in_ready` is 1 and every request, write and exception output is 0. `in_ready` is 0 from the cycle after an acceptance until the instruction retires.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and accepting |
| in_form | input | 1 | 0 indexed form, 1 immediate form |
| in_op2 | input | 4 | Indexed-form sub-opcode |
| in_r | input | 4 | r field: FP index (indexed) or sub-opcode (immediate) |
| in_s | input | 4 | Base register index |
| in_t | input | 4 | t field: FP index in the immediate form |
| in_imm | input | 8 | Unsigned word offset for the immediate form |
| in_base_val | input | 32 | Value of the base general register |
| in_index_val | input | 32 | Value of the index general register |
| in_fp_val | input | 32 | Value of the FP register named by the instruction |
| in_fp_present | input | 1 | Floating-point option present |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word address in bytes |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_rdata | input | 32 | Read data |
| fp_wr_en | output | 1 | FP register write strobe |
| fp_wr_idx | output | 4 | FP register index |
| fp_wr_data | output | 32 | FP register write data |
| base_wr_en | output | 1 | Base register write strobe |
| base_wr_idx | output | 4 | Base register index |
| base_wr_data | output | 32 | Updated base value |
| exc_reserved | output | 1 | Reserved encoding pulse |
| exc_no_fp | output | 1 | Missing floating-point option pulse |
| exc_align | output | 1 | Misaligned address pulse |

## Verification
The bench sweeps every reserved sub-opcode value in both forms. A decoder that used the wrong bit positions for one form would turn reserved codes into accesses, or would swap store with update. It also tries addresses that are off by one, two and three bytes, and sums that wrap past 2^32. A unit that checked alignment too late would issue a request or write a register. It also runs the option-absent case with both legal and reserved encodings to pin the exception priority. A store is followed by loads from the same address, and the memory stalls between zero and two cycles. A unit that wrote the base register before the response, or let the request drift while it was stalled, would show a mismatch there.

// File: rtl/fpls_pkg.sv
package fpls_pkg;

  typedef enum logic {
    FORM_INDEXED = 1'b0,
    FORM_IMMED   = 1'b1
  } fpls_form_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_REQ   = 2'd2,
    ST_RSP   = 2'd3
  } fpls_state_e;

  typedef struct packed {
    logic legal;
    logic store;
    logic update;
  } fpls_dec_t;

endpackage

// File: rtl/fpls_decode.sv
module fpls_decode
  import fpls_pkg::*;
#(
  parameter int SUB_W    = 4,
  parameter int IDX_W    = 4,
  parameter int X_ST_BIT = 2,
  parameter int X_UP_BIT = 0,
  parameter int I_ST_BIT = 2,
  parameter int I_UP_BIT = 3
) (
  input  logic             form,
  input  logic [SUB_W-1:0] op2,
  input  logic [IDX_W-1:0] r,
  input  logic [IDX_W-1:0] s,
  input  logic [IDX_W-1:0] t,
  output fpls_dec_t        dec,
  output logic [IDX_W-1:0] fp_idx,
  output logic [IDX_W-1:0] base_idx
);
  // Only the store and update bits may be set in a legal sub-opcode.
  localparam logic [SUB_W-1:0] X_MASK = SUB_W'((1 << X_ST_BIT) | (1 << X_UP_BIT));
  localparam logic [IDX_W-1:0] I_MASK = IDX_W'((1 << I_ST_BIT) | (1 << I_UP_BIT));

  always_comb begin
    if (form == FORM_IMMED) begin
      dec.legal  = (r & ~I_MASK) == '0;
      dec.store  = r[I_ST_BIT];
      dec.update = r[I_UP_BIT];
      fp_idx     = t;
    end else begin
      dec.legal  = (op2 & ~X_MASK) == '0;
      dec.store  = op2[X_ST_BIT];
      dec.update = op2[X_UP_BIT];
      fp_idx     = r;
    end
    base_idx = s;
  end
endmodule

// File: rtl/fpls_agen.sv
module fpls_agen
  import fpls_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 8,
  parameter int SCALE_SH = 2,
  parameter int ALIGN_LG = 2
) (
  input  logic              form,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] index_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] ea,
  output logic              misaligned
);
  localparam int PAD_W = DATA_W - IMM_W - SCALE_SH;

  logic [DATA_W-1:0] offset;

  // One adder serves both forms; only the second operand is muxed.
  always_comb begin
    if (form == FORM_IMMED) offset = {{PAD_W{1'b0}}, imm, {SCALE_SH{1'b0}}};
    else                    offset = index_val;
    ea         = base_val + offset;
    misaligned = |ea[ALIGN_LG-1:0];
  end
endmodule

// File: rtl/fpls_ctrl.sv
module fpls_ctrl
  import fpls_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int ALIGN_LG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  fpls_dec_t         dec,
  input  logic [DATA_W-1:0] ea,
  input  logic              misaligned,
  input  logic              fp_ok,
  input  logic [DATA_W-1:0] fp_val,
  input  logic [IDX_W-1:0]  fp_idx,
  input  logic [IDX_W-1:0]  base_idx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [DATA_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              fp_wr_en,
  output logic [IDX_W-1:0]  fp_wr_idx,
  output logic [DATA_W-1:0] fp_wr_data,
  output logic              base_wr_en,
  output logic [IDX_W-1:0]  base_wr_idx,
  output logic [DATA_W-1:0] base_wr_data,
  output logic              exc_reserved,
  output logic              exc_no_fp,
  output logic              exc_align
);
  fpls_state_e state;

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      fp_wr_en      <= 1'b0;
      fp_wr_idx     <= '0;
      fp_wr_data    <= '0;
      base_wr_en    <= 1'b0;
      base_wr_idx   <= '0;
      base_wr_data  <= '0;
      exc_reserved  <= 1'b0;
      exc_no_fp     <= 1'b0;
      exc_align     <= 1'b0;
    end else begin
      fp_wr_en     <= 1'b0;
      base_wr_en   <= 1'b0;
      exc_reserved <= 1'b0;
      exc_no_fp    <= 1'b0;
      exc_align    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) state <= ST_CHECK;
        end
        ST_CHECK: begin
          // Fault priority: encoding, then option, then alignment.
          if (!dec.legal) begin
            exc_reserved <= 1'b1;
            state        <= ST_IDLE;
          end else if (!fp_ok) begin
            exc_no_fp <= 1'b1;
            state     <= ST_IDLE;
          end else if (misaligned) begin
            exc_align <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= dec.store;
            mem_req_addr  <= ea;
            mem_req_wdata <= fp_val;
            state         <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_RSP;
          end
        end
        ST_RSP: begin
          if (mem_rsp_valid) begin
            fp_wr_en     <= !dec.store;
            fp_wr_idx    <= fp_idx;
            fp_wr_data   <= mem_rsp_rdata;
            base_wr_en   <= dec.update;
            base_wr_idx  <= base_idx;
            base_wr_data <= mem_req_addr;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata))
    else $error("request changed while stalled");

  assert_req_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[ALIGN_LG-1:0] == '0)
    else $error("misaligned request issued");

  assert_exc_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_reserved, exc_no_fp, exc_align}))
    else $error("more than one exception pulse");

  assert_exc_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_reserved || exc_no_fp || exc_align) |-> !mem_req_valid && !fp_wr_en && !base_wr_en)
    else $error("side effect alongside an exception");

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !mem_req_valid)
    else $error("ready while a request is pending");

  assert_wb_after_rsp_R7: assert property (@(posedge clk) disable iff (rst)
    (fp_wr_en || base_wr_en) |-> $past(mem_rsp_valid))
    else $error("writeback without a memory response");
endmodule

// File: rtl/fpls_unit.sv
module fpls_unit
  import fpls_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int SUB_W    = 4,
  parameter int IMM_W    = 8,
  parameter int SCALE_SH = 2,
  parameter int ALIGN_LG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_form,
  input  logic [SUB_W-1:0]  in_op2,
  input  logic [IDX_W-1:0]  in_r,
  input  logic [IDX_W-1:0]  in_s,
  input  logic [IDX_W-1:0]  in_t,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_base_val,
  input  logic [DATA_W-1:0] in_index_val,
  input  logic [DATA_W-1:0] in_fp_val,
  input  logic              in_fp_present,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [DATA_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic              fp_wr_en,
  output logic [IDX_W-1:0]  fp_wr_idx,
  output logic [DATA_W-1:0] fp_wr_data,
  output logic              base_wr_en,
  output logic [IDX_W-1:0]  base_wr_idx,
  output logic [DATA_W-1:0] base_wr_data,
  output logic              exc_reserved,
  output logic              exc_no_fp,
  output logic              exc_align
);
  logic              take;
  logic              form_q;
  logic [SUB_W-1:0]  op2_q;
  logic [IDX_W-1:0]  r_q, s_q, t_q;
  logic [IMM_W-1:0]  imm_q;
  logic [DATA_W-1:0] base_q, index_q, fpv_q;
  logic              fpok_q;

  fpls_dec_t         dec;
  logic [IDX_W-1:0]  fp_idx, base_idx;
  logic [DATA_W-1:0] ea;
  logic              misaligned;

  assign take = in_valid && in_ready;

  // Operands are captured once; they stay put until the unit is idle again.
  always_ff @(posedge clk) begin
    if (rst) begin
      form_q  <= 1'b0;
      op2_q   <= '0;
      r_q     <= '0;
      s_q     <= '0;
      t_q     <= '0;
      imm_q   <= '0;
      base_q  <= '0;
      index_q <= '0;
      fpv_q   <= '0;
      fpok_q  <= 1'b0;
    end else if (take) begin
      form_q  <= in_form;
      op2_q   <= in_op2;
      r_q     <= in_r;
      s_q     <= in_s;
      t_q     <= in_t;
      imm_q   <= in_imm;
      base_q  <= in_base_val;
      index_q <= in_index_val;
      fpv_q   <= in_fp_val;
      fpok_q  <= in_fp_present;
    end
  end

  fpls_decode #(.SUB_W(SUB_W), .IDX_W(IDX_W)) decode_i (
    .form     (form_q),
    .op2      (op2_q),
    .r        (r_q),
    .s        (s_q),
    .t        (t_q),
    .dec      (dec),
    .fp_idx   (fp_idx),
    .base_idx (base_idx)
  );

  fpls_agen #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SCALE_SH(SCALE_SH), .ALIGN_LG(ALIGN_LG)
  ) agen_i (
    .form       (form_q),
    .base_val   (base_q),
    .index_val  (index_q),
    .imm        (imm_q),
    .ea         (ea),
    .misaligned (misaligned)
  );

  fpls_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ALIGN_LG(ALIGN_LG)) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .dec           (dec),
    .ea            (ea),
    .misaligned    (misaligned),
    .fp_ok         (fpok_q),
    .fp_val        (fpv_q),
    .fp_idx        (fp_idx),
    .base_idx      (base_idx),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .fp_wr_en      (fp_wr_en),
    .fp_wr_idx     (fp_wr_idx),
    .fp_wr_data    (fp_wr_data),
    .base_wr_en    (base_wr_en),
    .base_wr_idx   (base_wr_idx),
    .base_wr_data  (base_wr_data),
    .exc_reserved  (exc_reserved),
    .exc_no_fp     (exc_no_fp),
    .exc_align     (exc_align)
  );

  assert_operands_held_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(base_q) && $stable(s_q))
    else $error("operands changed while busy");
endmodule

// File: tb/fpls_unit_tb.sv
`timescale 1ns/1ps
module fpls_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_form = 1'b0;
  logic [3:0]  in_op2 = '0, in_r = '0, in_s = '0, in_t = '0;
  logic [7:0]  in_imm = '0;
  logic [31:0] in_base_val = '0, in_index_val = '0, in_fp_val = '0;
  logic        in_fp_present = 1'b0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        fp_wr_en, base_wr_en;
  logic [3:0]  fp_wr_idx, base_wr_idx;
  logic [31:0] fp_wr_data, base_wr_data;
  logic        exc_reserved, exc_no_fp, exc_align;

  always #2 clk = ~clk;

  fpls_unit dut_i (.*);

  typedef struct {
    int          kind;   // 0 access, 1 reserved, 2 no option, 3 alignment
    bit          we;
    logic [31:0] addr;
    logic [31:0] wdata;
    bit          has_fp;
    logic [3:0]  fp_idx;
    logic [31:0] fp_data;
    bit          has_base;
    logic [3:0]  base_idx;
    logic [31:0] base_data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t pend_q[$];
  logic [31:0] ref_mem [int unsigned];
  logic [31:0] dev_mem [int unsigned];
  int checks = 0;
  int failures = 0;

  function automatic logic [31:0] fill_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic issue(input bit form, input logic [3:0] op2, input logic [3:0] r,
                       input logic [3:0] s, input logic [3:0] t, input logic [7:0] imm,
                       input logic [31:0] gs, input logic [31:0] gt, input logic [31:0] fpv,
                       input bit fpok, input string tag);
    exp_t e;
    logic [31:0] ea;
    bit legal, st, up;
    e = '{kind:0, we:0, addr:0, wdata:0, has_fp:0, fp_idx:0, fp_data:0,
          has_base:0, base_idx:0, base_data:0, tag:tag};
    if (!form) begin
      ea = gs + gt;
      legal = (op2 == 4'd0) || (op2 == 4'd1) || (op2 == 4'd4) || (op2 == 4'd5);
      st = op2[2]; up = op2[0]; e.fp_idx = r;
    end else begin
      ea = gs + {22'b0, imm, 2'b00};
      legal = (r == 4'd0) || (r == 4'd4) || (r == 4'd8) || (r == 4'd12);
      st = r[2]; up = r[3]; e.fp_idx = t;
    end
    if (!legal) e.kind = 1;
    else if (!fpok) e.kind = 2;
    else if (ea[1:0] != 2'b00) e.kind = 3;
    else begin
      e.we = st; e.addr = ea; e.wdata = fpv;
      e.has_fp = !st;
      e.fp_data = ref_mem.exists(ea) ? ref_mem[ea] : fill_word(ea);
      e.has_base = up; e.base_idx = s; e.base_data = ea;
      if (st) ref_mem[ea] = fpv;
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(e);
    in_valid = 1'b1; in_form = form; in_op2 = op2; in_r = r; in_s = s; in_t = t;
    in_imm = imm; in_base_val = gs; in_index_val = gt; in_fp_val = fpv;
    in_fp_present = fpok;
    @(negedge clk);
    chk(!in_ready, "R10", "ready while busy", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b0;
  endtask

  // Monitor and memory responder in one process.
  initial begin
    exp_t e;
    int stall = 0;
    int nreq = 0;
    int k;
    logic        cap_we;
    logic [31:0] cap_addr, cap_wdata;
    cap_we = 0; cap_addr = 0; cap_wdata = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      mem_rsp_valid = 1'b0;
      if (exc_reserved || exc_no_fp || exc_align) begin
        k = exc_reserved ? 1 : (exc_no_fp ? 2 : 3);
        if (exp_q.size() == 0) chk(0, "R9", "unexpected exception", k, 0);
        else begin
          e = exp_q.pop_front();
          chk(k == e.kind, e.tag, "exception kind", k, e.kind);
        end
      end
      if (fp_wr_en || base_wr_en) begin
        if (pend_q.size() == 0) chk(0, "R8", "unexpected writeback", 1, 0);
        else begin
          e = pend_q.pop_front();
          chk(fp_wr_en == e.has_fp, e.tag, "fp write strobe", {31'b0, fp_wr_en}, {31'b0, e.has_fp});
          if (e.has_fp) begin
            chk(fp_wr_idx == e.fp_idx, e.tag, "fp index", {28'b0, fp_wr_idx}, {28'b0, e.fp_idx});
            chk(fp_wr_data == e.fp_data, e.tag, "fp data", fp_wr_data, e.fp_data);
          end
          chk(base_wr_en == e.has_base, e.tag, "base strobe", {31'b0, base_wr_en}, {31'b0, e.has_base});
          if (e.has_base) begin
            chk(base_wr_idx == e.base_idx, e.tag, "base index", {28'b0, base_wr_idx}, {28'b0, e.base_idx});
            chk(base_wr_data == e.base_data, e.tag, "base data", base_wr_data, e.base_data);
          end
        end
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        if (cap_we) dev_mem[cap_addr] = cap_wdata;
        mem_rsp_rdata = cap_we ? 32'hDEAD_BEEF
                      : (dev_mem.exists(cap_addr) ? dev_mem[cap_addr] : fill_word(cap_addr));
        mem_rsp_valid = 1'b1;
      end else if (mem_req_valid) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 0) begin
          chk(0, "R8", "unexpected request", mem_req_addr, 0);
          mem_req_ready = 1'b1;
          cap_we = 1'b0; cap_addr = mem_req_addr; cap_wdata = 0;
        end else if (stall > 0) begin
          stall--;
          chk(mem_req_addr == exp_q[0].addr, "R11", "stalled address", mem_req_addr, exp_q[0].addr);
        end else begin
          e = exp_q.pop_front();
          chk(mem_req_addr == e.addr, e.tag, "request address", mem_req_addr, e.addr);
          chk(mem_req_we == e.we, e.tag, "request direction", {31'b0, mem_req_we}, {31'b0, e.we});
          if (e.we) chk(mem_req_wdata == e.wdata, e.tag, "store data", mem_req_wdata, e.wdata);
          if (e.has_fp || e.has_base) pend_q.push_back(e);
          mem_req_ready = 1'b1;
          cap_we = mem_req_we; cap_addr = mem_req_addr; cap_wdata = mem_req_wdata;
          nreq++;
          stall = nreq % 3;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle state after reset
    chk(in_ready == 1'b1, "R10", "reset ready", {31'b0, in_ready}, 32'd1);
    chk({mem_req_valid, fp_wr_en, base_wr_en, exc_reserved, exc_no_fp, exc_align} == 6'b0,
        "R10", "reset outputs", {26'b0, mem_req_valid, fp_wr_en, base_wr_en,
        exc_reserved, exc_no_fp, exc_align}, 32'd0);

    // R1 R5: indexed load; R6 store; R7 updates
    issue(0, 4'd0, 4'd3, 4'd1, 4'd2, 8'd0, 32'h0000_1000, 32'h20, 32'h0, 1, "R1");
    issue(0, 4'd4, 4'd5, 4'd1, 4'd2, 8'd0, 32'h0000_1000, 32'h40, 32'hCAFE_0001, 1, "R6");
    issue(0, 4'd1, 4'd6, 4'd7, 4'd2, 8'd0, 32'h0000_1000, 32'h40, 32'h0, 1, "R7");
    issue(0, 4'd5, 4'd8, 4'd9, 4'd2, 8'd0, 32'h0000_3000, 32'h8, 32'h1234_5678, 1, "R7");
    issue(0, 4'd0, 4'd10, 4'd1, 4'd2, 8'd0, 32'h0000_3004, 32'h4, 32'h0, 1, "R5");
    // R1: wrap-around sum
    issue(0, 4'd0, 4'd11, 4'd1, 4'd2, 8'd0, 32'hFFFF_FFF0, 32'h20, 32'h0, 1, "R1");

    // R2 R4: immediate form
    issue(1, 4'd0, 4'd0, 4'd2, 4'd9, 8'hFF, 32'h0000_2000, 32'h0, 32'h0, 1, "R2");
    issue(1, 4'd0, 4'd4, 4'd2, 4'd4, 8'h10, 32'h0000_2000, 32'h0, 32'hBEEF_0004, 1, "R4");
    issue(1, 4'd0, 4'd8, 4'd3, 4'd12, 8'h10, 32'h0000_2000, 32'h0, 32'h0, 1, "R4");
    issue(1, 4'd0, 4'd12, 4'd5, 4'd1, 8'h01, 32'h0000_2100, 32'h0, 32'hF00D_000C, 1, "R7");
    issue(1, 4'd0, 4'd0, 4'd2, 4'd13, 8'h41, 32'h0000_2000, 32'h0, 32'h0, 1, "R5");
    issue(1, 4'd0, 4'd0, 4'd2, 4'd14, 8'h40, 32'hFFFF_FF00, 32'h0, 32'h0, 1, "R2");

    // R3 R4: every reserved sub-opcode
    for (int v = 0; v < 16; v++)
      if (!(v == 0 || v == 1 || v == 4 || v == 5))
        issue(0, 4'(v), 4'd1, 4'd1, 4'd1, 8'd0, 32'h100, 32'h4, 32'h0, 1, "R3");
    for (int v = 0; v < 16; v++)
      if (v % 4 != 0)
        issue(1, 4'd0, 4'(v), 4'd1, 4'd1, 8'd1, 32'h100, 32'h0, 32'h0, 1, "R4");

    // R8: misaligned by 1, 2, 3 in both forms, stores included
    for (int b = 1; b < 4; b++) begin
      issue(0, 4'd5, 4'd1, 4'd1, 4'd2, 8'd0, 32'h0000_1000, 32'(b), 32'h7777_7777, 1, "R8");
      issue(1, 4'd8, 4'd0, 4'd1, 4'd2, 8'd3, 32'(32'h0000_1040 + b), 32'h0, 32'h0, 1, "R8");
    end
    // R8: faulted store left memory untouched
    issue(0, 4'd0, 4'd4, 4'd1, 4'd2, 8'd0, 32'h0000_1000, 32'h0, 32'h0, 1, "R8");

    // R9: option absent, legal and reserved encodings; absent plus misaligned
    issue(0, 4'd0, 4'd1, 4'd1, 4'd2, 8'd0, 32'h100, 32'h4, 32'h0, 0, "R9");
    issue(1, 4'd0, 4'd12, 4'd1, 4'd2, 8'd2, 32'h100, 32'h0, 32'h0, 0, "R9");
    issue(0, 4'd3, 4'd1, 4'd1, 4'd2, 8'd0, 32'h100, 32'h4, 32'h0, 0, "R9");
    issue(0, 4'd4, 4'd1, 4'd1, 4'd2, 8'd0, 32'h101, 32'h4, 32'h0, 0, "R9");

    // R11 R5: back-to-back loads under memory stalls
    for (int i = 0; i < 6; i++)
      issue(0, 4'd0, 4'(i), 4'd1, 4'd2, 8'd0, 32'h0000_4000, 32'(i * 4), 32'h0, 1, "R11");

    for (int w = 0; w < 200 && (exp_q.size() != 0 || pend_q.size() != 0); w++)
      @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "outstanding items", exp_q.size(), 0);
    chk(pend_q.size() == 0, "R7", "missing writebacks", pend_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule